// File: doc/BRIEF.md
# Three-wire serial EEPROM slave (64 x 16)

This block models a small serial EEPROM of 64 words, 16 bits each, reached over a three-wire serial link: a select line, a serial clock and a data line in each direction. A host raises select, sends a start bit and an eight-bit command holding a two-bit opcode and a six-bit word address, and then sends or receives data bits, one per rising serial clock edge. Reads, single-word and whole-array writes, single-word and whole-array erases, and the setting of a write-enable latch are supported. A read keeps streaming words at rising addresses that wrap around, for as long as select stays high.

The serial pins are sampled in one system clock domain. A rising serial clock edge is found by comparing the pin with a registered copy, so the host must hold each serial clock level for at least one system clock cycle. The serial pins carry bare bits with no back-pressure, so they stay plain pins rather than a valid/ready stream. A test-only tap port reads any array word directly and combinationally.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, `dout_o` is 1, the write-enable latch is clear, every array word reads 0x0000 on the tap port, and the block waits for a start bit.
- R2: Serial input is acted on only at a rising `sclk_i` edge while `cs_i` is 1. In the start-bit wait, 0 bits are ignored and a 1 bit starts a command.
- R3: After the start bit, exactly 8 command bits are taken MSB first. Bits 7:6 are the opcode and bits 5:0 are the word address.
- R4: Opcode 01 (write) takes 16 further data bits MSB first and stores them at the addressed word. This happens only when the latch is set.
- R5: Command 00 with bits 5:4 = 01 (write all) takes 16 data bits and stores that value in all 64 words. This happens only when the latch is set.
- R6: Opcode 11 (erase) sets the addressed word to 0xFFFF when the latch is set.
- R7: Command 00 with bits 5:4 = 10 (erase all) sets every word to 0xFFFF when the latch is set.
- R8: Command 00 with bits 5:4 = 11 sets the latch, and 00 with bits 5:4 = 00 clears it. While the latch is clear, write, write all, erase and erase all leave every word unchanged.
- R9: Opcode 10 (read) drives `dout_o` to 0 at the rising edge that completes the command. Each following rising edge presents the next bit of the addressed word, MSB first.
- R10: After 16 bits of a read, the address increments modulo 64 and the next word follows at once, with no new command.
- R11: After a write, write all, erase, erase all or latch command completes, further clock edges are ignored until `cs_i` falls.
- R12: A falling `cs_i` aborts any command, returns the block to the start-bit wait and sets `dout_o` to 1.
- R13: `tap_data_o` always shows the array word at `tap_addr_i`, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Serial select, active high |
| sclk_i | input | 1 | Serial clock, sampled by clk |
| din_i | input | 1 | Serial data from host |
| dout_o | output | 1 | Serial data to host |
| tap_addr_i | input | 6 | Test tap word address |
| tap_data_o | output | 16 | Test tap word contents |

## Verification
Every word is written with a value derived from its own address, so a wrong field split or a lost bit appears as a mismatch in a whole-array sweep. Reads starting just below the top of the array show the dummy bit, the bit order and the wrap from 63 to 0. The same command strings are also sent with select low, with leading zeros, in the post-command hold, with the latch clear, and cut short by select falling. Each of these must leave a different, predictable footprint on the array and on `dout_o`.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_HOLD
  } mw_state_e;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_WRALL  = 2'b01;
  localparam logic [1:0] SUB_ERALL  = 2'b10;
endpackage

// File: rtl/mw_edge.sv
`timescale 1ns/1ps
module mw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_i;
    end
  end

  // a serial edge counts only while select is high
  assign rise_o = cs_i & sclk_i & ~sclk_q;
  assign fall_o = cs_q & ~cs_i;
endmodule

// File: rtl/mw_store.sv
`timescale 1ns/1ps
module mw_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_all_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [ADDR_W-1:0] tap_addr_i,
  output logic [WORD_W-1:0] tap_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (wr_en_i && (wr_all_i || wr_addr_i == ADDR_W'(g)))
        mem[g] <= wr_data_i;
    end
  end

  assign rd_data_o  = mem[rd_addr_i];
  assign tap_data_o = mem[tap_addr_i];

  // R4 R6
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_all_i) |=> mem[$past(wr_addr_i)] == $past(wr_data_i));

  // R5 R7
  bulk_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_all_i) |=> (mem[0] == $past(wr_data_i)) && (mem[DEPTH-1] == $past(wr_data_i)));

  // R8
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mem[0]) && $stable(mem[DEPTH-1]));
endmodule

// File: rtl/mw_ctrl.sv
`timescale 1ns/1ps
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              wr_en_o,
  output logic              wr_all_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int MAX_W = (WORD_W > CMD_W) ? WORD_W : CMD_W;
  localparam int CNT_W = $clog2(MAX_W);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

  mw_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-1:0]  cmd;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] sbuf;
  logic              we_q;
  logic              dout_q;

  logic [CMD_W-1:0]  cmd_nxt;
  logic [WORD_W-1:0] data_nxt;
  logic [1:0]        op_nxt;
  logic [1:0]        sub_nxt;
  logic              cmd_done;
  logic              word_done;

  assign cmd_nxt   = {cmd[CMD_W-2:0], din_i};
  assign data_nxt  = {sbuf[WORD_W-2:0], din_i};
  assign op_nxt    = cmd_nxt[CMD_W-1 -: 2];
  assign sub_nxt   = cmd_nxt[ADDR_W-1 -: 2];
  assign cmd_done  = (state == ST_CMD) && (cnt == CMD_LAST);
  assign word_done = (cnt == WORD_LAST);
  assign rd_addr_o = (state == ST_CMD) ? cmd_nxt[ADDR_W-1:0] : addr + 1'b1;
  assign dout_o    = dout_q;

  always_comb begin
    wr_en_o   = 1'b0;
    wr_all_o  = 1'b0;
    wr_addr_o = cmd_nxt[ADDR_W-1:0];
    wr_data_o = '1;
    if (rise_i) begin
      if (cmd_done) begin
        if (op_nxt == OP_ERASE) begin
          wr_en_o = we_q;
        end else if (op_nxt == OP_SPECIAL && sub_nxt == SUB_ERALL) begin
          wr_en_o  = we_q;
          wr_all_o = 1'b1;
        end
      end else if (state == ST_WDATA && word_done) begin
        wr_en_o   = we_q;
        wr_all_o  = (cmd[CMD_W-1 -: 2] == OP_SPECIAL);
        wr_addr_o = cmd[ADDR_W-1:0];
        wr_data_o = data_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      cmd    <= '0;
      addr   <= '0;
      sbuf   <= '0;
      we_q   <= 1'b0;
      dout_q <= 1'b1;
    end else if (fall_i) begin
      state  <= ST_IDLE;
      dout_q <= 1'b1;
    end else if (rise_i) begin
      unique case (state)
        ST_IDLE: begin
          if (din_i) begin
            state <= ST_CMD;
            cnt   <= '0;
            cmd   <= '0;
          end
        end
        ST_CMD: begin
          cmd <= cmd_nxt;
          cnt <= cnt + 1'b1;
          if (cnt == CMD_LAST) begin
            cnt <= '0;
            unique case (op_nxt)
              OP_WRITE: begin
                state <= ST_WDATA;
                sbuf  <= '0;
              end
              OP_READ: begin
                state  <= ST_RDATA;
                addr   <= cmd_nxt[ADDR_W-1:0];
                sbuf   <= rd_data_i;
                dout_q <= 1'b0;
              end
              OP_ERASE: state <= ST_HOLD;
              default: begin
                if (sub_nxt == SUB_WRALL) begin
                  state <= ST_WDATA;
                  sbuf  <= '0;
                end else begin
                  state <= ST_HOLD;
                  if (sub_nxt != SUB_ERALL) we_q <= cmd_nxt[ADDR_W-2];
                end
              end
            endcase
          end
        end
        ST_WDATA: begin
          sbuf <= data_nxt;
          cnt  <= cnt + 1'b1;
          if (word_done) state <= ST_HOLD;
        end
        ST_RDATA: begin
          dout_q <= sbuf[WORD_W-1];
          if (word_done) begin
            cnt  <= '0;
            addr <= addr + 1'b1;
            sbuf <= rd_data_i;
          end else begin
            cnt  <= cnt + 1'b1;
            sbuf <= sbuf << 1;
          end
        end
        default: ;
      endcase
    end
  end

  // R12
  cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_i |=> (state == ST_IDLE) && dout_o);

  // R1 R3
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_CMD) |-> dout_o);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !fall_i) |=> state == ST_HOLD);

  // R9
  rd_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && cmd_done && op_nxt == OP_READ) |=> (state == ST_RDATA) && !dout_o);

  // R8
  we_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_CMD) |=> $stable(we_q));

  // R10
  rd_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDATA) |-> !wr_en_o);
endmodule

// File: rtl/mw_eeprom.sv
`timescale 1ns/1ps
module mw_eeprom #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  input  logic [ADDR_W-1:0] tap_addr_i,
  output logic [WORD_W-1:0] tap_data_o
);
  logic              rise;
  logic              fall;
  logic              wr_en;
  logic              wr_all;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;

  mw_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_i   (cs_i),
    .sclk_i (sclk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  mw_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (rise),
    .fall_i    (fall),
    .din_i     (din_i),
    .dout_o    (dout_o),
    .wr_en_o   (wr_en),
    .wr_all_o  (wr_all),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data)
  );

  mw_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .wr_all_i   (wr_all),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .tap_addr_i (tap_addr_i),
    .tap_data_o (tap_data_o)
  );
endmodule

// File: tb/mw_eeprom_tb.sv
`timescale 1ns/1ps
module mw_eeprom_tb;
  localparam int AW    = 6;
  localparam int WW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs = 1'b0;
  logic          sclk = 1'b0;
  logic          din = 1'b0;
  logic          dout;
  logic [AW-1:0] tap_addr = '0;
  logic [WW-1:0] tap_data;

  int            checks = 0;
  int            errors = 0;
  logic [WW-1:0] refm [DEPTH];
  bit            ref_we = 1'b0;

  always #2.5 clk = ~clk;

  mw_eeprom u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_i       (cs),
    .sclk_i     (sclk),
    .din_i      (din),
    .dout_o     (dout),
    .tap_addr_i (tap_addr),
    .tap_data_o (tap_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic d);
    @(negedge clk) begin din = d; sclk = 1'b0; end
    @(negedge clk) sclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic cs_up();
    @(negedge clk) begin cs = 1'b1; sclk = 1'b0; end
    @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk) begin cs = 1'b0; sclk = 1'b0; end
    repeat (2) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [5:0] a);
    logic [7:0] c;
    c = {op, a};
    sbit(1'b1);
    for (int i = 7; i >= 0; i--) sbit(c[i]);
  endtask

  task automatic send_word(input logic [WW-1:0] w);
    for (int i = WW - 1; i >= 0; i--) sbit(w[i]);
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      tap_addr = AW'(a);
      #0.5;
      chk(req, 32'(tap_data), 32'(refm[a]));
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [WW-1:0] w);
    cs_up(); send_cmd(2'b01, a); send_word(w); cs_down();
    if (ref_we) refm[a] = w;
  endtask

  task automatic do_latch(input bit e);
    cs_up(); send_cmd(2'b00, e ? 6'b110000 : 6'b000000); cs_down();
    ref_we = e;
  endtask

  task automatic do_erase(input logic [5:0] a);
    cs_up(); send_cmd(2'b11, a); cs_down();
    if (ref_we) refm[a] = '1;
  endtask

  task automatic do_wrall(input logic [WW-1:0] w);
    cs_up(); send_cmd(2'b00, 6'b010110); send_word(w); cs_down();
    if (ref_we) for (int a = 0; a < DEPTH; a++) refm[a] = w;
  endtask

  task automatic do_erall();
    cs_up(); send_cmd(2'b00, 6'b101001); cs_down();
    if (ref_we) for (int a = 0; a < DEPTH; a++) refm[a] = '1;
  endtask

  task automatic do_read(input logic [5:0] a, input int nw);
    cs_up(); send_cmd(2'b10, a);
    chk("R9 dummy", 32'(dout), 32'd0);
    for (int w = 0; w < nw; w++) begin
      for (int b = WW - 1; b >= 0; b--) begin
        sbit(1'b0);
        if (w == 0) chk("R9 bit", 32'(dout), 32'(refm[6'(a + w)][b]));
        else        chk("R10 next", 32'(dout), 32'(refm[6'(a + w)][b]));
      end
    end
    cs_down();
    chk("R12 dout high", 32'(dout), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) refm[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dout", 32'(dout), 32'd1);
    sweep("R1");

    // R8: write with latch clear is dropped
    do_write(6'd5, 16'hA55A);
    sweep("R8");

    // R4 R3: fill every word with an address-derived value
    do_latch(1'b1);
    for (int a = 0; a < DEPTH; a++) do_write(6'(a), 16'(a * 16'h0101) ^ 16'h3C5A);
    sweep("R3");
    sweep("R4");

    // R9 R10 reads with wrap
    do_read(6'd62, 4);
    do_read(6'd0, 2);

    // R6 erase, then R11 hold ignores a following write in the same select
    cs_up(); send_cmd(2'b11, 6'd7); send_cmd(2'b01, 6'd8); send_word(16'h1111); cs_down();
    refm[7] = '1;
    sweep("R11");
    do_erase(6'd9);
    sweep("R6");

    // R2: leading zeros ignored before the start bit
    cs_up(); sbit(1'b0); sbit(1'b0); sbit(1'b0);
    send_cmd(2'b01, 6'd10); send_word(16'hBEEF); cs_down();
    refm[10] = 16'hBEEF;
    sweep("R2 zeros");

    // R2: clocking with select low does nothing
    @(negedge clk) cs = 1'b0;
    send_cmd(2'b01, 6'd12); send_word(16'h0F0F);
    chk("R2 dout", 32'(dout), 32'd1);
    sweep("R2 cs low");

    // R12: abort mid-command, then a fresh command works
    cs_up(); sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b1); cs_down();
    chk("R12 abort dout", 32'(dout), 32'd1);
    do_write(6'd11, 16'h600D);
    sweep("R12");
    cs_up(); send_cmd(2'b10, 6'd2); sbit(1'b0); sbit(1'b0); sbit(1'b0); cs_down();
    chk("R12 read abort", 32'(dout), 32'd1);

    // R5 write all, R7 erase all
    do_wrall(16'h1234);
    sweep("R5");
    do_erall();
    sweep("R7");
    do_write(6'd3, 16'h0003);
    do_write(6'd63, 16'hC0DE);

    // R8: everything blocked once the latch is cleared
    do_latch(1'b0);
    do_erase(6'd3);
    do_write(6'd4, 16'h4444);
    do_wrall(16'h5555);
    do_erall();
    sweep("R8 blocked");
    do_read(6'd63, 2);

    // R13 tap port shows each word without delay
    sweep("R13");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule